// File: doc/BRIEF.md
# Streaming Karatsuba Split-and-Add Stage

This stage carries out one level of Karatsuba pre-splitting on a polynomial that streams in one limb per cycle. The coefficients come in ascending order of degree. Each coefficient is a group of `LIMBS` consecutive limbs of `LIMB_W` bits, least significant limb first. The beats of the lower half of the polynomial are stored in a small ring buffer. When the upper half arrives, each stored limb is read back at the same offset and added to the incoming limb. A carry register links the limbs of one coefficient.

The stage has two output channels. The pass channel repeats every input beat one cycle later, so it carries the lower half followed by the upper half. The sum channel carries the sub-polynomial low-plus-high and is busy only while the upper half streams. Both channels have a valid flag and a start marker, so stages of half the length (`N_COEF/2`) can be cascaded on each channel. The sum is not reduced by any modulus: it wraps at `LIMB_W*LIMBS` bits, and the operands are expected to leave headroom for this.

Top module: `ksplit_stage`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released, and before any input beat, `pass_valid`, `pass_first`, `sum_valid` and `sum_first` are 0.
- R2: Every beat accepted with `in_valid`=1 appears on `pass_limb` with `pass_valid`=1 exactly one cycle later. Beats keep their order.
- R3: `sum_valid` stays 0 while beats 0 to `N_COEF*LIMBS/2 - 1` of a polynomial are accepted. It is 1 one cycle after each beat of the upper half.
- R4: For upper-half coefficient j+`N_COEF/2`, the sum channel delivers coefficient (low_j + high_j) mod 2^(`LIMB_W*LIMBS`) as `LIMBS` limbs, least significant first. Each limb is emitted in the same cycle as the pass-channel copy of the matching upper-half limb.
- R5: The carry out of a limb feeds the next limb of the same coefficient. No carry crosses from one coefficient into the next, including the carry out of the top limb.
- R6: `pass_first` is 1 only with the pass copy of beat 0 of a polynomial. `sum_first` is 1 only with the first sum limb, which is beat `N_COEF*LIMBS/2`. The two markers are never 1 together.
- R7: An input beat with `in_first`=1 is taken as beat 0 of a new polynomial, whatever position the stage was tracking. A partial earlier polynomial is abandoned.
- R8: Cycles with `in_valid`=0 do not advance the beat position or the carry, and they produce no valid output on either channel.
- R9: Polynomials may follow each other with no idle cycle between them. The beat position wraps to 0 after beat `N_COEF*LIMBS - 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_first | input | 1 | Input beat is beat 0 of a polynomial |
| in_limb | input | LIMB_W | Input limb |
| pass_valid | output | 1 | Pass channel beat present |
| pass_first | output | 1 | Pass channel beat 0 of a polynomial |
| pass_limb | output | LIMB_W | Pass channel limb |
| sum_valid | output | 1 | Sum channel beat present |
| sum_first | output | 1 | First limb of the sum sub-polynomial |
| sum_limb | output | LIMB_W | Sum channel limb |

## Verification
The bench drives coefficients whose limbs are all ones. Every sum then overflows both inside the coefficient and out of its top limb, so a carry that is never propagated, or one that leaks into the next coefficient, shows up as a value that is off by one. A ripple pattern, where the lower limbs are all ones and the upper operand is 1, tests carry propagation through all limbs. Idle cycles inside the stream would shift the read-back offset, or fire the sum channel on a dead cycle, in a design that counted cycles instead of beats. A back-to-back pair and a restart from a partial polynomial expose wrong wrap and resync handling, which would misplace the start markers or add the wrong low-half coefficient.

// File: rtl/ksplit_pkg.sv
package ksplit_pkg;
  // Position class of the beat currently on the input
  typedef struct packed {
    logic low_half;    // beat belongs to the first half of the polynomial
    logic coef_start;  // least significant limb of a coefficient
    logic poly_start;  // beat 0 of the polynomial
    logic sum_start;   // first beat of the upper half
  } beat_tag_t;
endpackage

// File: rtl/ksplit_beat_ctr.sv
module ksplit_beat_ctr
  import ksplit_pkg::*;
#(
  parameter int N_COEF = 8,
  parameter int LIMBS  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_first,
  output logic [((N_COEF*LIMBS/2) > 1 ? $clog2(N_COEF*LIMBS/2) : 1)-1:0] pos,
  output beat_tag_t tag
);
  localparam int TOTAL = N_COEF * LIMBS;
  localparam int HALF  = TOTAL / 2;
  localparam int CW    = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam int PW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int LW    = (LIMBS > 1) ? $clog2(LIMBS) : 1;
  localparam logic [CW-1:0] LAST_BEAT = CW'(TOTAL - 1);
  localparam logic [CW-1:0] HALF_BEAT = CW'(HALF);
  localparam logic [LW-1:0] LAST_LIMB = LW'(LIMBS - 1);

  logic [CW-1:0] cnt_q, idx;
  logic [LW-1:0] lcnt_q, limb;
  logic          upper;

  // A marked beat restarts the framing (R7)
  always_comb begin
    idx   = in_first ? '0 : cnt_q;
    limb  = in_first ? '0 : lcnt_q;
    upper = (idx >= HALF_BEAT);
    pos   = upper ? PW'(idx - HALF_BEAT) : PW'(idx);
    tag.low_half   = !upper;
    tag.coef_start = (limb == '0);
    tag.poly_start = (idx == '0);
    tag.sum_start  = (idx == HALF_BEAT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lcnt_q <= '0;
    end else if (in_valid) begin
      cnt_q  <= (idx == LAST_BEAT) ? '0 : idx + CW'(1);
      lcnt_q <= (limb == LAST_LIMB) ? '0 : limb + LW'(1);
    end
  end

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cnt_q) && $stable(lcnt_q));
  assert_ctr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= LAST_BEAT) && (lcnt_q <= LAST_LIMB));
endmodule

// File: rtl/ksplit_ring.sv
module ksplit_ring #(
  parameter int W     = 27,
  parameter int DEPTH = 20,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  // Written in address order during the low half, read back at the
  // same addresses during the high half: first in, first out.
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(addr) < DEPTH));
endmodule

// File: rtl/ksplit_limb_adder.sv
module ksplit_limb_adder #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         first_limb,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  // {carry_out, limb_sum} of one limb step
  function automatic logic [W:0] limb_step(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic         cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  logic         carry_q;
  logic         cin_used;
  logic [W:0]   step;

  assign cin_used = first_limb ? 1'b0 : carry_q;   // R5: no carry across coefficients
  assign step     = limb_step(a, b, cin_used);
  assign sum      = step[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)  carry_q <= 1'b0;
    else if (en) carry_q <= step[W];
  end

  assert_carry_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(carry_q));
endmodule

// File: rtl/ksplit_stage.sv
module ksplit_stage
  import ksplit_pkg::*;
#(
  parameter int LIMB_W = 27,
  parameter int LIMBS  = 5,
  parameter int N_COEF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [LIMB_W-1:0] in_limb,
  output logic              pass_valid,
  output logic              pass_first,
  output logic [LIMB_W-1:0] pass_limb,
  output logic              sum_valid,
  output logic              sum_first,
  output logic [LIMB_W-1:0] sum_limb
);
  localparam int HALF_BEATS = N_COEF * LIMBS / 2;
  localparam int PW         = (HALF_BEATS > 1) ? $clog2(HALF_BEATS) : 1;

  beat_tag_t         tag;
  logic [PW-1:0]     pos;
  logic [LIMB_W-1:0] low_limb;
  logic [LIMB_W-1:0] add_limb;
  logic              beat_push;   // low-half beat stored
  logic              beat_pop;    // high-half beat combined

  ksplit_beat_ctr #(.N_COEF(N_COEF), .LIMBS(LIMBS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .pos(pos), .tag(tag)
  );

  assign beat_push = in_valid & tag.low_half;
  assign beat_pop  = in_valid & ~tag.low_half;

  ksplit_ring #(.W(LIMB_W), .DEPTH(HALF_BEATS)) u_ring (
    .clk(clk), .rst_n(rst_n), .we(beat_push), .addr(pos),
    .wdata(in_limb), .rdata(low_limb)
  );

  ksplit_limb_adder #(.W(LIMB_W)) u_add (
    .clk(clk), .rst_n(rst_n), .en(beat_pop), .first_limb(tag.coef_start),
    .a(low_limb), .b(in_limb), .sum(add_limb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_valid <= 1'b0;
      pass_first <= 1'b0;
      pass_limb  <= '0;
      sum_valid  <= 1'b0;
      sum_first  <= 1'b0;
      sum_limb   <= '0;
    end else begin
      pass_valid <= in_valid;
      pass_first <= in_valid & tag.poly_start;
      if (in_valid) pass_limb <= in_limb;
      sum_valid  <= beat_pop;
      sum_first  <= beat_pop & tag.sum_start;
      if (beat_pop) sum_limb <= add_limb;
    end
  end

  assert_sum_needs_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> pass_valid);
  assert_pass_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> pass_valid && (pass_limb == $past(in_limb)));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !pass_valid && !sum_valid);
  assert_sum_first_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sum_first |-> sum_valid);
  assert_pass_first_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_first |-> pass_valid);
  assert_markers_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass_first, sum_first}));
endmodule

// File: tb/ksplit_stage_bench.sv
module ksplit_stage_bench;
  localparam int LW = 27, LN = 5, NC = 8;
  localparam int CWD = LW * LN, TOT = NC * LN, HB = TOT / 2;
  // Table: {pattern[1:0], idle_between_coefficients}
  // pattern 0 random 125-bit, 1 all ones, 2 carry ripple, 3 zero low / random high
  localparam logic [2:0] VEC [6] = '{3'b000, 3'b010, 3'b100, 3'b110, 3'b001, 3'b011};

  logic clk = 0, rst_n = 0, in_valid = 0, in_first = 0;
  logic [LW-1:0] in_limb = '0;
  logic pass_valid, pass_first, sum_valid, sum_first;
  logic [LW-1:0] pass_limb, sum_limb;
  int checks = 0, errors = 0;

  logic [CWD-1:0] stim [NC];
  logic [LW-1:0] pcap [200], scap [200];
  int pn = 0, sn = 0, npf = 0, nsf = 0, early = 0;
  int pfp [4], sfp [4];
  logic cap_en = 0;

  always #5 clk = ~clk;

  ksplit_stage #(.LIMB_W(LW), .LIMBS(LN), .N_COEF(NC)) u_ksplit_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first), .in_limb(in_limb),
    .pass_valid(pass_valid), .pass_first(pass_first), .pass_limb(pass_limb),
    .sum_valid(sum_valid), .sum_first(sum_first), .sum_limb(sum_limb));

  always @(negedge clk) if (cap_en) begin
    if (sum_valid) begin
      if ((pn % TOT) < HB) early++;
      if (sn < 200) scap[sn] = sum_limb;
      if (sum_first && nsf < 4) begin sfp[nsf] = pn; nsf++; end
      sn++;
    end
    if (pass_valid) begin
      if (pn < 200) pcap[pn] = pass_limb;
      if (pass_first && npf < 4) begin pfp[npf] = pn; npf++; end
      pn++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [CWD-1:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_cap();
    @(posedge clk); #1;
    pn = 0; sn = 0; npf = 0; nsf = 0; early = 0; cap_en = 1;
  endtask

  task automatic fill(input logic [1:0] pat);
    for (int c = 0; c < NC; c++) begin
      logic [127:0] r;
      r = {$urandom, $urandom, $urandom, $urandom};
      case (pat)
        2'd0: stim[c] = CWD'(r[124:0]);
        2'd1: stim[c] = '1;
        2'd2: stim[c] = (c < NC/2) ? CWD'({(LW*(LN-1)){1'b1}}) : CWD'(1);
        default: stim[c] = (c < NC/2) ? '0 : CWD'(r[124:0]);
      endcase
    end
  endtask

  task automatic send(input int ncoef, input bit gap);
    for (int c = 0; c < ncoef; c++) begin
      for (int l = 0; l < LN; l++) begin
        @(negedge clk);
        in_valid = 1; in_first = (c == 0 && l == 0);
        in_limb = stim[c][l*LW +: LW];
      end
      if (gap) begin @(negedge clk); in_valid = 0; in_first = 0; end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); in_valid = 0; in_first = 0; end
  endtask

  // Compare one captured polynomial against the reference split-and-add
  task automatic verify(input int poff, input int soff);
    for (int c = 0; c < NC; c++) begin
      logic [CWD-1:0] got;
      for (int l = 0; l < LN; l++) got[l*LW +: LW] = pcap[poff + c*LN + l];
      chk(got == stim[c], "R2 pass coefficient", got, stim[c]);
    end
    for (int j = 0; j < NC/2; j++) begin
      logic [CWD-1:0] got, expv;
      expv = stim[j] + stim[j + NC/2];
      for (int l = 0; l < LN; l++) got[l*LW +: LW] = scap[soff + j*LN + l];
      chk(got == expv, "R4 R5 sum coefficient", got, expv);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!pass_valid && !sum_valid && !pass_first && !sum_first, "R1 in reset", 
        CWD'({pass_valid, sum_valid, pass_first, sum_first}), '0);
    rst_n = 1;
    @(negedge clk);
    chk(!pass_valid && !sum_valid && !pass_first && !sum_first, "R1 after release",
        CWD'({pass_valid, sum_valid, pass_first, sum_first}), '0);

    // R2 latency and R8 idle on a single marked beat
    in_valid = 1; in_first = 1; in_limb = 27'h5A5A5A5;
    @(negedge clk);
    chk(pass_valid && pass_first && pass_limb == 27'h5A5A5A5, "R2 one-cycle pass",
        CWD'(pass_limb), CWD'(27'h5A5A5A5));
    in_valid = 0; in_first = 0;
    @(negedge clk);
    chk(!pass_valid && !sum_valid, "R8 idle gives no output", CWD'({pass_valid, sum_valid}), '0);

    // Table-driven polynomials
    foreach (VEC[v]) begin
      fill(VEC[v][2:1]);
      clear_cap();
      send(NC, VEC[v][0]);
      idle(3);
      chk(pn == TOT, "R2 R8 pass beat count", CWD'(pn), CWD'(TOT));
      chk(sn == HB, "R3 sum beat count", CWD'(sn), CWD'(HB));
      chk(early == 0, "R3 no sum in low half", CWD'(early), '0);
      chk(npf == 1 && pfp[0] == 0, "R6 pass_first position", CWD'(pfp[0]), '0);
      chk(nsf == 1 && sfp[0] == HB, "R6 sum_first position", CWD'(sfp[0]), CWD'(HB));
      verify(0, 0);
    end

    // R9 back-to-back polynomials with no idle cycle
    fill(2'd1);
    clear_cap();
    send(NC, 0);
    send(NC, 0);
    idle(3);
    chk(pn == 2*TOT && sn == 2*HB, "R9 back-to-back counts", CWD'(pn), CWD'(2*TOT));
    chk(npf == 2 && pfp[1] == TOT, "R9 second pass_first", CWD'(pfp[1]), CWD'(TOT));
    chk(nsf == 2 && sfp[1] == TOT + HB, "R9 second sum_first", CWD'(sfp[1]), CWD'(TOT + HB));
    verify(0, 0);
    verify(TOT, HB);

    // R7 restart after a partial polynomial of three coefficients
    fill(2'd0);
    clear_cap();
    send(3, 0);
    fill(2'd0);
    send(NC, 0);
    idle(3);
    chk(pn == 3*LN + TOT, "R7 restart pass count", CWD'(pn), CWD'(3*LN + TOT));
    chk(sn == HB, "R7 restart sum count", CWD'(sn), CWD'(HB));
    chk(nsf == 1 && sfp[0] == 3*LN + HB, "R7 sum_first after restart", CWD'(sfp[0]), CWD'(3*LN + HB));
    verify(3*LN, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule